// File: doc/BRIEF.md
# One-Hot Control Word Checker

This block watches the decoded control lines of one or more finite-state-machine processes. In a correct controller, each process drives exactly one of its decoded state lines high in every cycle. For each process, the block translates that word into a set of two-rail pairs. It then folds those pairs through a tree of two-rail checker cells, which yields one dual-rail result for that process. A compactor tree built from the same cells merges the per-process results into a single dual-rail result for the whole controller. A pair whose two rails differ means the code is valid. A pair whose two rails are equal means an error.

Each line of a process has an index. The translator assigns every index bit position one pair. The true rail of that pair is the OR of all lines whose index has that bit set. The false rail is the OR of all lines whose index has that bit clear. A single active line therefore sets exactly one rail of every pair. No active line leaves every pair at zero. Any two active lines differ in at least one index bit, so that pair sees both rails high.

Some state lines can be marked as intrinsically secure with a mask parameter. A faulty control word in those states is already caught elsewhere. The marked lines are ORed into one shared line before translation, which reduces the effective width. The effective width must be at least four, and elaboration stops with an error if it is not. The block is purely combinational and has no clock. Any register on its outputs belongs to the surrounding design. There is no data stream, so there is no valid/ready handshake.

Top module: `onehot_ctrl_guard`

## Requirements
- R1: When exactly one effective line of a process is 1, that process's pair (`proc_t[p]`, `proc_f[p]`) has unequal rails.
- R2: When no line of a process is 1, that process's pair has equal rails.
- R3: When two or more effective lines of a process are 1, that process's pair has equal rails.
- R4: Lines marked in `IS_MASK` count together as one effective line, so any non-empty set of marked lines with no unmarked line active yields unequal rails.
- R5: A marked line active together with any unmarked line yields equal rails.
- R6: The merged pair (`sum_t`, `sum_f`) has unequal rails if and only if every process pair has unequal rails.
- R7: Process `p` owns lines `ctrl_lines[p*NLINES +: NLINES]`. Bit `i` of `IS_MASK` marks line `i` of every process.
- R8: Outputs follow the inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_lines | input | NPROC*NLINES | Decoded state lines of all processes, process 0 in the low bits |
| proc_t | output | NPROC | True rail of each process's result |
| proc_f | output | NPROC | False rail of each process's result |
| sum_t | output | 1 | True rail of the merged result |
| sum_f | output | 1 | False rail of the merged result |

## Verification
Two functions can act on the same input word: merging the intrinsically secure lines, and counting the unmarked lines. A word that activates marked lines together with an unmarked line exercises both. The bench judges it against a reference count in which all marked lines add at most one. Per-process checking and compaction also meet in a single vector. The bench sweeps every combination of two processes, so that one valid and one faulty word coexist. It then expects the merged pair to be invalid while the valid process's own pair stays valid.

// File: rtl/otc_pkg.sv
package otc_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  function automatic logic rail_good(input rail_t r);
    return r.t ^ r.f;
  endfunction
endpackage

// File: rtl/otc_rail_cell.sv
module otc_rail_cell
  import otc_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  assign y.t = (a.t & b.f) | (a.f & b.t);
  assign y.f = (a.t & b.t) | (a.f & b.f);

  always_comb begin
    // R6: two good inputs always give a good output
    p_cell_pass_r6: assert (!(rail_good(a) && rail_good(b)) || rail_good(y));
    // R6: a bad input is never masked
    p_cell_block_r6: assert (rail_good(a) && rail_good(b) || !rail_good(y));
  end
endmodule

// File: rtl/otc_rail_tree.sv
module otc_rail_tree
  import otc_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  rail_t [PAIRS-1:0] leaf,
  output rail_t             root
);
  localparam int NODES = 2*PAIRS - 1;

  rail_t [NODES-1:0] node;

  genvar i;
  generate
    for (i = 0; i < PAIRS; i++) begin : g_leaf
      assign node[i] = leaf[i];
    end
    for (i = 0; i < PAIRS-1; i++) begin : g_cell
      otc_rail_cell u_cell (
        .a(node[2*i]),
        .b(node[2*i+1]),
        .y(node[PAIRS+i])
      );
    end
  endgenerate

  assign root = node[NODES-1];
endmodule

// File: rtl/otc_is_merge.sv
module otc_is_merge #(
  parameter int               NLINES  = 6,
  parameter logic [NLINES-1:0] IS_MASK = '0,
  localparam int NIS   = $countones(IS_MASK),
  localparam int NPLAIN = NLINES - NIS,
  localparam int EFF_N = NPLAIN + ((NIS > 0) ? 1 : 0)
) (
  input  logic [NLINES-1:0] lines,
  output logic [EFF_N-1:0]  eff
);
  logic [EFF_N-1:0] packed_plain;

  always_comb begin
    int k;
    packed_plain = '0;
    k = 0;
    for (int i = 0; i < NLINES; i++) begin
      if (!IS_MASK[i]) begin
        packed_plain[k] = lines[i];
        k = k + 1;
      end
    end
  end

  generate
    if (NIS > 0) begin : g_secure
      logic shared;
      assign shared = |(lines & IS_MASK);
      always_comb begin
        eff = packed_plain;
        eff[EFF_N-1] = shared;
      end
      always_comb begin
        // R4: any active marked line must reach the shared line
        p_secure_seen_r4: assert (!(|(lines & IS_MASK)) || eff[EFF_N-1]);
      end
    end else begin : g_plain
      assign eff = packed_plain;
    end
  endgenerate

  always_comb begin
    // R5: the number of active unmarked lines is preserved
    p_plain_count_r5: assert ($countones(lines & ~IS_MASK) ==
                              $countones(eff) - ((NIS > 0 && (|(lines & IS_MASK))) ? 1 : 0));
  end
endmodule

// File: rtl/otc_code_xlate.sv
module otc_code_xlate
  import otc_pkg::*;
#(
  parameter int EFF_N = 6,
  localparam int NB = $clog2(EFF_N)
) (
  input  logic [EFF_N-1:0] eff,
  output rail_t [NB-1:0]   pair
);
  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bit
      always_comb begin
        pair[b].t = 1'b0;
        pair[b].f = 1'b0;
        for (int idx = 0; idx < EFF_N; idx++) begin
          if (((idx >> b) & 1) == 1) pair[b].t = pair[b].t | eff[idx];
          else                       pair[b].f = pair[b].f | eff[idx];
        end
      end
    end
  endgenerate

  always_comb begin
    logic all_good;
    logic all_zero;
    all_good = 1'b1;
    all_zero = 1'b1;
    for (int q = 0; q < NB; q++) begin
      all_good = all_good & rail_good(pair[q]);
      all_zero = all_zero & ~pair[q].t & ~pair[q].f;
    end
    // R1: a single active line gives a full codeword
    p_single_good_r1: assert (!$onehot(eff) || all_good);
    // R2: no active line leaves every rail low
    p_empty_low_r2: assert ((|eff) || all_zero);
    // R3: multiple active lines break at least one pair
    p_multi_bad_r3: assert (!($countones(eff) > 1) || !all_good);
  end
endmodule

// File: rtl/otc_proc_check.sv
module otc_proc_check
  import otc_pkg::*;
#(
  parameter int               NLINES  = 6,
  parameter logic [NLINES-1:0] IS_MASK = '0,
  localparam int NIS   = $countones(IS_MASK),
  localparam int EFF_N = NLINES - NIS + ((NIS > 0) ? 1 : 0),
  localparam int NB    = $clog2(EFF_N)
) (
  input  logic [NLINES-1:0] lines,
  output rail_t             res
);
  generate
    if (EFF_N < 4) begin : g_too_narrow
      $error("effective line count must be at least four");
    end
  endgenerate

  logic [EFF_N-1:0] eff;
  rail_t [NB-1:0]   pair;

  otc_is_merge #(.NLINES(NLINES), .IS_MASK(IS_MASK)) u_merge (
    .lines(lines),
    .eff  (eff)
  );

  otc_code_xlate #(.EFF_N(EFF_N)) u_xlate (
    .eff (eff),
    .pair(pair)
  );

  otc_rail_tree #(.PAIRS(NB)) u_tree (
    .leaf(pair),
    .root(res)
  );

  always_comb begin
    // R1: one effective line active gives a valid result
    p_proc_valid_r1: assert (!($countones(eff) == 1) || rail_good(res));
    // R3: several effective lines active give an error
    p_proc_error_r3: assert (($countones(eff) == 1) || !rail_good(res));
  end
endmodule

// File: rtl/onehot_ctrl_guard.sv
module onehot_ctrl_guard
  import otc_pkg::*;
#(
  parameter int               NLINES  = 6,
  parameter int               NPROC   = 2,
  parameter logic [NLINES-1:0] IS_MASK = '0,
  localparam int WIDTH = NLINES * NPROC
) (
  input  logic [WIDTH-1:0] ctrl_lines,
  output logic [NPROC-1:0] proc_t,
  output logic [NPROC-1:0] proc_f,
  output logic             sum_t,
  output logic             sum_f
);
  rail_t [NPROC-1:0] pr;
  rail_t             merged;

  genvar p;
  generate
    for (p = 0; p < NPROC; p++) begin : g_proc
      otc_proc_check #(.NLINES(NLINES), .IS_MASK(IS_MASK)) u_chk (
        .lines(ctrl_lines[p*NLINES +: NLINES]),
        .res  (pr[p])
      );
      assign proc_t[p] = pr[p].t;
      assign proc_f[p] = pr[p].f;
    end
  endgenerate

  otc_rail_tree #(.PAIRS(NPROC)) u_compact (
    .leaf(pr),
    .root(merged)
  );

  assign sum_t = merged.t;
  assign sum_f = merged.f;

  always_comb begin
    // R6: merged result is valid exactly when every process is valid
    p_merge_valid_r6: assert ((sum_t ^ sum_f) == (&(proc_t ^ proc_f)));
  end
endmodule

// File: tb/sim_onehot_ctrl_guard.sv
module sim_onehot_ctrl_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // u0: two processes of six lines, no marked lines
  logic [11:0] vec0;
  logic [1:0]  p0_t, p0_f;
  logic        s0_t, s0_f;

  onehot_ctrl_guard #(.NLINES(6), .NPROC(2), .IS_MASK(6'b000000)) u0 (
    .ctrl_lines(vec0),
    .proc_t    (p0_t),
    .proc_f    (p0_f),
    .sum_t     (s0_t),
    .sum_f     (s0_f)
  );

  // u1: one process of eight lines, top two marked (effective width 7)
  localparam logic [7:0] MASK1 = 8'b1100_0000;
  logic [7:0] vec1;
  logic [0:0] p1_t, p1_f;
  logic       s1_t, s1_f;

  onehot_ctrl_guard #(.NLINES(8), .NPROC(1), .IS_MASK(MASK1)) u1 (
    .ctrl_lines(vec1),
    .proc_t    (p1_t),
    .proc_f    (p1_f),
    .sum_t     (s1_t),
    .sum_f     (s1_f)
  );

  function automatic int eff_count(input logic [7:0] v, input logic [7:0] m);
    return $countones(v & ~m) + ((|(v & m)) ? 1 : 0);
  endfunction

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual valid=%0b expected valid=%0b", req, what, got, exp);
    end
  endtask

  function automatic string tag_of(input int cnt);
    if (cnt == 0) return "R2";
    if (cnt == 1) return "R1";
    return "R3";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    vec0 = '0;
    vec1 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all lines low is an error everywhere (R2)
    check("R2", p0_t[0] ^ p0_f[0], 1'b0, "idle proc0");
    check("R2", s0_t ^ s0_f, 1'b0, "idle merged");
    check("R2", p1_t[0] ^ p1_f[0], 1'b0, "idle marked cfg");

    // R8: input change observed with no clock edge in between
    vec0 = 12'b000100_000001;
    #1;
    check("R8", s0_t ^ s0_f, 1'b1, "combinational follow");

    // exhaustive sweep, two processes (R1 R2 R3 R6 R7)
    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      vec0 = v[11:0];
      @(negedge clk);
      begin
        int c0, c1;
        logic g0, g1;
        c0 = $countones(v[5:0]);
        c1 = $countones(v[11:6]);
        g0 = (c0 == 1);
        g1 = (c1 == 1);
        check(tag_of(c0), p0_t[0] ^ p0_f[0], g0, $sformatf("proc0 word %03h", v));
        check(tag_of(c1), p0_t[1] ^ p0_f[1], g1, $sformatf("proc1 word %03h R7", v));
        check("R6", s0_t ^ s0_f, g0 & g1, $sformatf("merged word %03h", v));
      end
    end

    // exhaustive sweep with marked lines (R4 R5)
    for (int v = 0; v < 256; v++) begin
      @(posedge clk);
      vec1 = v[7:0];
      @(negedge clk);
      begin
        int cnt;
        int plain;
        logic any_is;
        string tg;
        cnt = eff_count(v[7:0], MASK1);
        plain = $countones(v[7:0] & ~MASK1);
        any_is = |(v[7:0] & MASK1);
        if (any_is && plain == 0) tg = "R4";
        else if (any_is) tg = "R5";
        else tg = tag_of(cnt);
        check(tg, p1_t[0] ^ p1_f[0], cnt == 1, $sformatf("marked cfg word %02h", v));
        check("R6", s1_t ^ s1_f, cnt == 1, $sformatf("single-proc merged %02h", v));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule